// File: doc/BRIEF.md
# Sample Format Converter

This block translates audio samples between a 32-bit buffer container and the 24-bit word used by a signal processor, in either direction. A 3-bit format code selects one of eight mappings. There is a 7-bit mode whose top bit is always forced high, a 16-bit mode, and two 24-bit alignments. A 32-bit mode splits each sample into two processor words. The three remaining codes mean the transfer is skipped.

A transfer opens with a `start` pulse, which captures the format code and the direction. The transfer stays open until `done` is seen. While it is open, samples pass through valid/ready handshakes on both sides.

Buffer-to-processor direction: one container is accepted and then emitted as one or two 24-bit words. Processor-to-buffer direction: one or two words are gathered into one container.

A single container register holds the sample in flight. Address generation, buffer wrap and descriptor handling are done elsewhere.

Top module: `fmt_conv`

## Requirements
- R1: A `start` pulse while idle captures `fmt` and `dir` (0 = buffer to processor, 1 = processor to buffer) and raises `busy`. A `start` while `busy` is high changes neither the format in use nor `skip`. While idle, every ready and valid output is low.
- R2: Code 0, buffer to processor: the word is {container[7:0] OR 0x80, 16'h0}. Processor to buffer: the container is {24'h0, word[23:16] OR 0x80}.
- R3: Code 1, buffer to processor: the word is {container[15:0], 8'h0}. Processor to buffer: the container is {16'h0, word[23:8]}.
- R4: Code 2, buffer to processor: the word is container[31:8]. Processor to buffer: the container is {word, 8'h0}.
- R5: Code 6, buffer to processor: the word is container[23:0]. Processor to buffer: the container is {8'h0, word}.
- R6: Code 3, buffer to processor: the first word is container[31:8] and the second is {16'h0, container[7:0]}. `buf_in_ready` stays low until both words have been taken. Processor to buffer: the container is {first word, second word[7:0]}, and no container is offered after the first word alone.
- R7: Codes 4, 5 and 7 hold `skip` high for the whole transfer. All readies and valids stay low, so no data moves.
- R8: An offered output (`dsp_out_valid` or `buf_out_valid`) keeps its data and stays valid until the matching ready is seen.
- R9: `done` closes the transfer on the next edge. `busy` falls, and a half-gathered or unsent sample is discarded.
- R10: A word is offered on the cycle after its container is accepted. A container is offered on the cycle after its last word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opens a transfer when idle |
| fmt | input | 3 | Format code, captured at start |
| dir | input | 1 | Direction, captured at start |
| done | input | 1 | Closes the open transfer |
| busy | output | 1 | Transfer open |
| skip | output | 1 | Open transfer uses a skipped format code |
| buf_in_valid | input | 1 | Buffer container offered |
| buf_in_ready | output | 1 | Converter takes a container |
| buf_in_data | input | 32 | Container from buffer |
| dsp_out_valid | output | 1 | Processor word offered |
| dsp_out_ready | input | 1 | Processor takes the word |
| dsp_out_data | output | 24 | Word to processor |
| dsp_in_valid | input | 1 | Processor word offered |
| dsp_in_ready | output | 1 | Converter takes a word |
| dsp_in_data | input | 24 | Word from processor |
| buf_out_valid | output | 1 | Container offered to buffer |
| buf_out_ready | input | 1 | Buffer takes the container |
| buf_out_data | output | 32 | Container to buffer |

## Verification
Each handshake moves through exactly one register, so every result is due one edge after its stimulus. A first word appears one edge after its container is accepted. The split second word appears one edge after the first is taken. A container appears one edge after the last word is taken. `busy` and `skip` follow one edge after `start` or `done`. The bench drives inputs on the falling edge and samples on the next falling edge, so each check lands exactly half a period after the edge that produced the result. Stall checks hold the ready low for several such samples and compare data at each one.

// File: rtl/fmt_conv.sv
module fmt_conv (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  fmt,
  input  logic        dir,
  input  logic        done,
  output logic        busy,
  output logic        skip,
  input  logic        buf_in_valid,
  output logic        buf_in_ready,
  input  logic [31:0] buf_in_data,
  output logic        dsp_out_valid,
  input  logic        dsp_out_ready,
  output logic [23:0] dsp_out_data,
  input  logic        dsp_in_valid,
  output logic        dsp_in_ready,
  input  logic [23:0] dsp_in_data,
  output logic        buf_out_valid,
  input  logic        buf_out_ready,
  output logic [31:0] buf_out_data
);
  localparam logic [2:0] F_7B = 3'd0, F_16 = 3'd1, F_24H = 3'd2, F_32 = 3'd3, F_24L = 3'd6;

  logic        active, dir_r, full, phase;
  logic [2:0]  fmt_r;
  logic [31:0] cont;

  wire rsv  = (fmt_r == 3'd4) || (fmt_r == 3'd5) || (fmt_r == 3'd7);
  wire go   = active & ~rsv;
  wire is32 = (fmt_r == F_32);

  assign busy          = active;
  assign skip          = active & rsv;
  assign buf_in_ready  = go & ~dir_r & ~full;
  assign dsp_out_valid = go & ~dir_r & full;
  assign dsp_in_ready  = go & dir_r & ~full;
  assign buf_out_valid = go & dir_r & full;
  assign buf_out_data  = cont;

  always_comb begin
    case (fmt_r)
      F_7B:    dsp_out_data = {cont[7:0] | 8'h80, 16'h0};
      F_16:    dsp_out_data = {cont[15:0], 8'h0};
      F_24H:   dsp_out_data = cont[31:8];
      F_32:    dsp_out_data = phase ? {16'h0, cont[7:0]} : cont[31:8];
      F_24L:   dsp_out_data = cont[23:0];
      default: dsp_out_data = 24'h0;
    endcase
  end

  function automatic logic [31:0] pack(input logic [2:0] f, input logic [23:0] w);
    case (f)
      F_7B:    pack = {24'h0, w[23:16] | 8'h80};
      F_16:    pack = {16'h0, w[23:8]};
      F_24H:   pack = {w, 8'h0};
      default: pack = {8'h0, w};
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      dir_r  <= 1'b0;
      fmt_r  <= 3'd0;
      full   <= 1'b0;
      phase  <= 1'b0;
      cont   <= 32'h0;
    end else if (!active) begin
      if (start) begin
        active <= 1'b1;
        fmt_r  <= fmt;
        dir_r  <= dir;
        full   <= 1'b0;
        phase  <= 1'b0;
      end
    end else if (done) begin
      active <= 1'b0;
      full   <= 1'b0;
      phase  <= 1'b0;
    end else begin
      if (buf_in_valid && buf_in_ready) begin
        cont  <= buf_in_data;
        full  <= 1'b1;
        phase <= 1'b0;
      end
      if (dsp_out_valid && dsp_out_ready) begin
        if (is32 && !phase) phase <= 1'b1;
        else begin
          full  <= 1'b0;
          phase <= 1'b0;
        end
      end
      if (dsp_in_valid && dsp_in_ready) begin
        if (is32 && !phase) begin
          cont[31:8] <= dsp_in_data;
          phase      <= 1'b1;
        end else if (is32) begin
          cont[7:0] <= dsp_in_data[7:0];
          full      <= 1'b1;
          phase     <= 1'b0;
        end else begin
          cont <= pack(fmt_r, dsp_in_data);
          full <= 1'b1;
        end
      end
      if (buf_out_valid && buf_out_ready) full <= 1'b0;
    end
  end
endmodule

// File: rtl/fmt_conv_chk.sv
module fmt_conv_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        done,
  input logic        busy,
  input logic        skip,
  input logic        buf_in_valid,
  input logic        buf_in_ready,
  input logic        dsp_out_valid,
  input logic        dsp_out_ready,
  input logic [23:0] dsp_out_data,
  input logic        dsp_in_ready,
  input logic        buf_out_valid,
  input logic        buf_out_ready,
  input logic [31:0] buf_out_data
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(buf_in_ready || dsp_in_ready || dsp_out_valid || buf_out_valid)); // R1
  AST_SKIP_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(skip)); // R1
  AST_SPLIT_READY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    buf_in_valid && buf_in_ready && !done |=> !buf_in_ready); // R6
  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> !(buf_in_ready || dsp_in_ready || dsp_out_valid || buf_out_valid)); // R7
  AST_DSP_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_out_valid && !dsp_out_ready && !done |=> dsp_out_valid && $stable(dsp_out_data)); // R8
  AST_BUF_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    buf_out_valid && !buf_out_ready && !done |=> buf_out_valid && $stable(buf_out_data)); // R8
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && done |=> !busy); // R9
  AST_WORD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    buf_in_valid && buf_in_ready && !done |=> dsp_out_valid); // R10
endmodule

bind fmt_conv fmt_conv_chk chk_i (.*);

// File: tb/fmt_conv_tb_top.sv
module fmt_conv_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, dir = 1'b0, done = 1'b0;
  logic [2:0] fmt = 3'd0;
  logic busy, skip;
  logic buf_in_valid = 1'b0, dsp_out_ready = 1'b0, dsp_in_valid = 1'b0, buf_out_ready = 1'b0;
  logic [31:0] buf_in_data = 32'h0;
  logic [23:0] dsp_in_data = 24'h0;
  logic buf_in_ready, dsp_out_valid, dsp_in_ready, buf_out_valid;
  logic [23:0] dsp_out_data;
  logic [31:0] buf_out_data;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  fmt_conv dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic open_xfer(input logic [2:0] f, input logic d);
    @(negedge clk); start = 1'b1; fmt = f; dir = d;
    @(negedge clk); start = 1'b0;
    chk("R1 busy after start", {31'h0, busy}, 32'd1);
  endtask

  task automatic close_xfer();
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
    chk("R9 busy after done", {31'h0, busy}, 32'd0);
  endtask

  task automatic b2d(input string tag, input logic [31:0] c, input logic [23:0] w0,
                     input logic two, input logic [23:0] w1);
    chk({tag, " in ready"}, {31'h0, buf_in_ready}, 32'd1);
    buf_in_valid = 1'b1; buf_in_data = c;
    @(negedge clk); buf_in_valid = 1'b0;
    chk({tag, " R10 word valid"}, {31'h0, dsp_out_valid}, 32'd1);
    chk({tag, " word0"}, {8'h0, dsp_out_data}, {8'h0, w0});
    dsp_out_ready = 1'b1;
    if (two) begin
      chk({tag, " R6 ready low"}, {31'h0, buf_in_ready}, 32'd0);
      @(negedge clk);
      chk({tag, " R6 ready low 2nd"}, {31'h0, buf_in_ready}, 32'd0);
      chk({tag, " word1"}, {8'h0, dsp_out_data}, {8'h0, w1});
    end
    @(negedge clk); dsp_out_ready = 1'b0;
    chk({tag, " drained"}, {31'h0, dsp_out_valid}, 32'd0);
  endtask

  task automatic d2b(input string tag, input logic [23:0] w0, input logic two,
                     input logic [23:0] w1, input logic [31:0] c);
    chk({tag, " in ready"}, {31'h0, dsp_in_ready}, 32'd1);
    dsp_in_valid = 1'b1; dsp_in_data = w0;
    @(negedge clk);
    if (two) begin
      chk({tag, " R6 no early container"}, {31'h0, buf_out_valid}, 32'd0);
      dsp_in_data = w1;
      @(negedge clk);
    end
    dsp_in_valid = 1'b0;
    chk({tag, " R10 container valid"}, {31'h0, buf_out_valid}, 32'd1);
    chk({tag, " container"}, buf_out_data, c);
    buf_out_ready = 1'b1;
    @(negedge clk); buf_out_ready = 1'b0;
    chk({tag, " drained"}, {31'h0, buf_out_valid}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 reset busy", {31'h0, busy}, 32'd0);
    chk("R1 reset quiet", {28'h0, buf_in_ready, dsp_in_ready, dsp_out_valid, buf_out_valid}, 32'd0);
  endtask

  task automatic t_b2d_all();
    open_xfer(3'd0, 1'b0);
    b2d("R2 b2d a", 32'hABCDEF12, 24'h920000, 1'b0, 24'h0);
    b2d("R2 b2d b", 32'h000000FF, 24'hFF0000, 1'b0, 24'h0);
    close_xfer();
    open_xfer(3'd1, 1'b0);
    b2d("R3 b2d", 32'h12345678, 24'h567800, 1'b0, 24'h0);
    close_xfer();
    open_xfer(3'd2, 1'b0);
    b2d("R4 b2d", 32'hDEADBEEF, 24'hDEADBE, 1'b0, 24'h0);
    close_xfer();
    open_xfer(3'd6, 1'b0);
    b2d("R5 b2d", 32'hDEADBEEF, 24'hADBEEF, 1'b0, 24'h0);
    close_xfer();
    open_xfer(3'd3, 1'b0);
    b2d("R6 b2d", 32'hCAFEF00D, 24'hCAFEF0, 1'b1, 24'h00000D);
    close_xfer();
  endtask

  task automatic t_d2b_all();
    open_xfer(3'd0, 1'b1);
    d2b("R2 d2b", 24'h3C5A5A, 1'b0, 24'h0, 32'h000000BC);
    close_xfer();
    open_xfer(3'd1, 1'b1);
    d2b("R3 d2b", 24'hBEEF77, 1'b0, 24'h0, 32'h0000BEEF);
    close_xfer();
    open_xfer(3'd2, 1'b1);
    d2b("R4 d2b", 24'h123456, 1'b0, 24'h0, 32'h12345600);
    close_xfer();
    open_xfer(3'd6, 1'b1);
    d2b("R5 d2b", 24'h654321, 1'b0, 24'h0, 32'h00654321);
    close_xfer();
    open_xfer(3'd3, 1'b1);
    d2b("R6 d2b", 24'h89ABCD, 1'b1, 24'hFFFF5E, 32'h89ABCD5E);
    close_xfer();
  endtask

  task automatic t_skip();
    for (int k = 0; k < 3; k++) begin
      logic [2:0] f;
      f = (k == 0) ? 3'd4 : (k == 1) ? 3'd5 : 3'd7;
      open_xfer(f, k[0]);
      chk("R7 skip high", {31'h0, skip}, 32'd1);
      buf_in_valid = 1'b1; dsp_in_valid = 1'b1;
      repeat (3) begin
        @(negedge clk);
        chk("R7 nothing moves", {28'h0, buf_in_ready, dsp_in_ready, dsp_out_valid, buf_out_valid}, 32'd0);
      end
      buf_in_valid = 1'b0; dsp_in_valid = 1'b0;
      close_xfer();
      chk("R7 skip low after done", {31'h0, skip}, 32'd0);
    end
  endtask

  task automatic t_restart_ignored();
    open_xfer(3'd1, 1'b0);
    @(negedge clk); start = 1'b1; fmt = 3'd4; dir = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R1 start while busy no skip", {31'h0, skip}, 32'd0);
    b2d("R1 format kept", 32'h0000A1B2, 24'hA1B200, 1'b0, 24'h0);
    close_xfer();
  endtask

  task automatic t_stall();
    open_xfer(3'd3, 1'b0);
    buf_in_valid = 1'b1; buf_in_data = 32'h11223344;
    @(negedge clk); buf_in_valid = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk("R8 dsp word held", {7'h0, dsp_out_valid, dsp_out_data}, {8'h01, 24'h112233});
    end
    close_xfer();
    open_xfer(3'd2, 1'b1);
    dsp_in_valid = 1'b1; dsp_in_data = 24'hA5A5A5;
    @(negedge clk); dsp_in_valid = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk("R8 container held", buf_out_data, 32'hA5A5A500);
      chk("R8 container valid", {31'h0, buf_out_valid}, 32'd1);
    end
    close_xfer();
  endtask

  task automatic t_done_discard();
    open_xfer(3'd3, 1'b1);
    dsp_in_valid = 1'b1; dsp_in_data = 24'h777777;
    @(negedge clk); dsp_in_valid = 1'b0;
    close_xfer();
    chk("R9 idle quiet", {31'h0, buf_out_valid}, 32'd0);
    open_xfer(3'd3, 1'b1);
    dsp_in_valid = 1'b1; dsp_in_data = 24'h010203;
    @(negedge clk); dsp_in_valid = 1'b0;
    chk("R9 half sample dropped", {31'h0, buf_out_valid}, 32'd0);
    dsp_in_valid = 1'b1; dsp_in_data = 24'h0000F4;
    @(negedge clk); dsp_in_valid = 1'b0;
    chk("R9 fresh container", buf_out_data, 32'h010203F4);
    close_xfer();
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_b2d_all();
        t_d2b_all();
        t_skip();
        t_restart_ignored();
        t_stall();
        t_done_discard();
      end
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule